// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Programmable Level Flags

This block is a first-in first-out word buffer with a write side and a read side, each on its own clock. The two clocks may be one clock or fully unrelated, and writes and reads may happen in the same cycle. Words are 9 bits wide. The depth is a power of two from 64 to 8192 words, set by the `DEPTH` parameter.

The stream interfaces follow valid/ready rules built from plain pins. On the write side, the pair `wr_en_n` low and `wr_en_ld` high is the valid, and `full` low is the ready. A word offered while `full` is high is dropped, so the producer must hold it until `full` falls. On the read side, the pair `rd_en_n` low and `rd_en` high is the request, and `empty` low is the valid. A request made while `empty` is high does nothing.

Two status flags carry programmable levels: `almost_empty` and `almost_full`. Their offsets are loaded through the write data port while reset is held. Each flag is computed in the clock domain of the side that acts on it. The read data sits in an output register and drives `rd_q` only while `out_en` is high.

Top module: `dcf_fifo9`

## Requirements
- R1: Words leave in the order they were accepted. A read accepted at a rising `rd_clk` edge places the oldest stored word on `rd_q` right after that edge. `rd_q` resets to 0.
- R2: A word is stored at a rising `wr_clk` edge when `wr_en_n`=0, `wr_en_ld`=1, `full`=0 and `rst`=0. A word is taken on every such edge, with no idle cycle. With either enable at its inactive level, the write pointer stays put.
- R3: A write offered while `full`=1 is dropped. It leaves the contents, the order and the write pointer unchanged.
- R4: A read is accepted at a rising `rd_clk` edge when `rd_en_n`=0, `rd_en`=1, `empty`=0 and `rst`=0. A read is taken on every such edge. `empty` rises on the same edge that takes the last word.
- R5: A read requested while `empty`=1 is ignored. The output register keeps its value and the read pointer stays put.
- R6: `empty` falls on the third rising read-clock edge after the write edge that made the FIFO non-empty. With the clocks tied, this is the third edge after the write.
- R7: `full` rises on the write edge that stores word number `DEPTH`. It falls on the third rising write-clock edge after the read that frees a slot.
- R8: `almost_empty` is 1 when the read side's word count is at most the low-mark offset. Its timing is the same as `empty`, and `empty`=1 implies `almost_empty`=1.
- R9: `almost_full` is 1 when the write side's word count plus the high-mark offset is at least `DEPTH`. Its timing is the same as `full`, and `full`=1 implies `almost_full`=1.
- R10: Offsets are loaded from `wr_data[8:0]` on rising `wr_clk` edges while `rst`=1, `wr_en_ld`=0 and `wr_en_n`=0. The first such edge loads the low-mark offset, and the next loads the high-mark offset. Loading then wraps back to the low mark.
- R11: At a rising `wr_clk` edge with `rst`=1 and `wr_en_ld`=1, both offsets return to 7 and loading restarts at the low mark. While `rst` is held, the flags read `empty`=1, `almost_empty`=1, `full`=0 and `almost_full`=0.
- R12: While `out_en`=0, `rd_q` is released to high impedance. Reads and the output register are unaffected, so raising `out_en` shows the word most recently read.
- R13: Each pointer crosses to the other domain as Gray code through two flip-flops. The registered Gray value changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, free running |
| rd_clk | input | 1 | Read-side clock, free running |
| rst | input | 1 | Active-high reset; clears pointers and flags asynchronously; qualifies offset loading on `wr_clk` |
| wr_data | input | 9 | Word to store, or an offset value during reset |
| wr_en_n | input | 1 | Write enable, active low; load strobe during reset |
| wr_en_ld | input | 1 | Write enable, active high; selects loading (0) or restoring defaults (1) during reset |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en | input | 1 | Read enable, active high |
| out_en | input | 1 | Drives `rd_q` when 1, releases it when 0 |
| rd_q | output | 9 | Registered read word |
| empty | output | 1 | No word visible to the read side (read domain) |
| almost_empty | output | 1 | Read-side count at or below the low-mark offset (read domain) |
| full | output | 1 | `DEPTH` words held (write domain) |
| almost_full | output | 1 | Write-side count plus the high-mark offset reaches `DEPTH` (write domain) |

## Verification
The bench ties both clocks together. This fixes every result's latency:

- Read data appears on `rd_q` right after the read edge.
- `empty` and `full` rise on the same edge as the access that causes them.
- `empty` and `almost_empty` fall three edges after a write.
- `full` and `almost_full` fall three edges after a read.

The behavioural model advances on each rising edge from the inputs alone. It keeps a three-entry history of the write and read totals, so it can reproduce the other domain's delayed view of each total. Inputs change 1 ns after a rising edge, and every output is compared at the following falling edge. Each comparison therefore sees values that have settled for the cycle in question.

// File: rtl/dcf_fifo_pkg.sv
package dcf_fifo_pkg;

  localparam int WORD_W = 9;
  localparam int OFF_W  = 9;

  localparam logic [OFF_W-1:0] OFF_DEFAULT = 9'd7;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFF_W-1:0]  off_t;

  // which threshold the next load strobe writes
  typedef enum logic {
    SEL_LOW_MARK  = 1'b0,
    SEL_HIGH_MARK = 1'b1
  } offsel_e;

endpackage

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 9,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Unregistered read; the read side owns the output register.
  assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  logic [PW-1:0] stage1;
  logic [PW-1:0] stage2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits.
  for (genvar i = 0; i < PW; i++) begin : g_dec
    assign bin_out[i] = ^stage2[PW-1:i];
  end

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  word_t         din,
  input  logic          en_n,
  input  logic          en_ld,
  input  logic [PW-1:0] rd_bin_sync,
  output logic          push,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray,
  output logic          full,
  output logic          afull,
  output off_t          ae_off
);

  localparam int CW = ((PW > OFF_W) ? PW : OFF_W) + 1;

  off_t          af_off;
  offsel_e       sel;
  logic          want;
  logic [PW-1:0] bin_nx;
  logic [PW-1:0] cnt_nx;
  logic [CW-1:0] fill_plus;

  assign want      = ~en_n & en_ld;
  assign push      = want & ~full & ~rst;
  assign bin_nx    = bin + PW'(push);
  assign cnt_nx    = bin_nx - rd_bin_sync;
  assign fill_plus = CW'(cnt_nx) + CW'(af_off);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bin   <= '0;
      gray  <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
    end else begin
      bin   <= bin_nx;
      gray  <= bin_nx ^ (bin_nx >> 1);
      full  <= (cnt_nx == PW'(DEPTH));
      afull <= (fill_plus >= CW'(DEPTH));
    end
  end

  // Threshold register: written only while reset is held, sampled on clk.
  always_ff @(posedge clk) begin
    if (rst) begin
      if (en_ld) begin
        ae_off <= OFF_DEFAULT;
        af_off <= OFF_DEFAULT;
        sel    <= SEL_LOW_MARK;
      end else if (!en_n) begin
        if (sel == SEL_LOW_MARK) begin
          ae_off <= din;
          sel    <= SEL_HIGH_MARK;
        end else begin
          af_off <= din;
          sel    <= SEL_LOW_MARK;
        end
      end
    end
  end

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_n,
  input  logic          en,
  input  logic [PW-1:0] wr_bin_sync,
  input  off_t          ae_off,
  input  word_t         mem_word,
  output logic          pop,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray,
  output word_t         q,
  output logic          empty,
  output logic          aempty
);

  localparam int CW = ((PW > OFF_W) ? PW : OFF_W) + 1;

  logic [PW-1:0] bin_nx;
  logic [PW-1:0] cnt_nx;

  assign pop    = ~en_n & en & ~empty & ~rst;
  assign bin_nx = bin + PW'(pop);
  assign cnt_nx = wr_bin_sync - bin_nx;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bin    <= '0;
      gray   <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
      q      <= '0;
    end else begin
      bin    <= bin_nx;
      gray   <= bin_nx ^ (bin_nx >> 1);
      empty  <= (cnt_nx == '0);
      aempty <= (CW'(cnt_nx) <= CW'(ae_off));
      if (pop) q <= mem_word;
    end
  end

endmodule

// File: rtl/dcf_fifo9.sv
module dcf_fifo9
  import dcf_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_en_n,
  input  logic              wr_en_ld,
  input  logic              rd_en_n,
  input  logic              rd_en,
  input  logic              out_en,
  output wire  [WORD_W-1:0] rd_q,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr_bin;
  logic [PW-1:0] wr_ptr_gray;
  logic [PW-1:0] rd_ptr_bin;
  logic [PW-1:0] rd_ptr_gray;
  logic [PW-1:0] rd_ptr_in_wr;
  logic [PW-1:0] wr_ptr_in_rd;
  logic          push;
  logic          pop;
  word_t         ram_word;
  word_t         rd_word;
  off_t          low_mark;

  dcf_wr_side #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk         (wr_clk),
    .rst         (rst),
    .din         (wr_data),
    .en_n        (wr_en_n),
    .en_ld       (wr_en_ld),
    .rd_bin_sync (rd_ptr_in_wr),
    .push        (push),
    .bin         (wr_ptr_bin),
    .gray        (wr_ptr_gray),
    .full        (full),
    .afull       (almost_full),
    .ae_off      (low_mark)
  );

  dcf_ptr_sync #(.PW(PW)) u_sync_r2w (
    .clk     (wr_clk),
    .rst     (rst),
    .gray_in (rd_ptr_gray),
    .bin_out (rd_ptr_in_wr)
  );

  dcf_ptr_sync #(.PW(PW)) u_sync_w2r (
    .clk     (rd_clk),
    .rst     (rst),
    .gray_in (wr_ptr_gray),
    .bin_out (wr_ptr_in_rd)
  );

  dcf_ram #(.DEPTH(DEPTH), .DW(WORD_W), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (push),
    .waddr (wr_ptr_bin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rd_ptr_bin[AW-1:0]),
    .rdata (ram_word)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .PW(PW)) u_rd (
    .clk         (rd_clk),
    .rst         (rst),
    .en_n        (rd_en_n),
    .en          (rd_en),
    .wr_bin_sync (wr_ptr_in_rd),
    .ae_off      (low_mark),
    .mem_word    (ram_word),
    .pop         (pop),
    .bin         (rd_ptr_bin),
    .gray        (rd_ptr_gray),
    .q           (rd_word),
    .empty       (empty),
    .aempty      (almost_empty)
  );

  assign rd_q = out_en ? rd_word : 'z;

endmodule

// File: rtl/dcf_fifo9_chk.sv
module dcf_fifo9_chk #(
  parameter int PW = 7
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_en_n,
  input logic          wr_en_ld,
  input logic          rd_en_n,
  input logic          rd_en,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray,
  input logic [8:0]    rd_word
);

  // R3: an offered write while full moves nothing
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (rst)
    (full && !wr_en_n && wr_en_ld) |=> $stable(wr_ptr));

  // R2: without both enables active the write pointer holds
  a_r2_wr_idle_hold: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en_n || !wr_en_ld) |=> $stable(wr_ptr));

  // R2: the write pointer advances by exactly one when it moves
  a_r2_wr_step_one: assert property (@(posedge wr_clk) disable iff (rst)
    !$stable(wr_ptr) |-> (wr_ptr == $past(wr_ptr) + 1'b1));

  // R5: a read while empty moves nothing
  a_r5_no_underflow: assert property (@(posedge rd_clk) disable iff (rst)
    (empty && !rd_en_n && rd_en) |=> $stable(rd_ptr));

  // R5: the output register holds unless a read is taken
  a_r5_word_hold: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_en_n || !rd_en || empty) |=> $stable(rd_word));

  // R4: the read pointer advances by exactly one when it moves
  a_r4_rd_step_one: assert property (@(posedge rd_clk) disable iff (rst)
    !$stable(rd_ptr) |-> (rd_ptr == $past(rd_ptr) + 1'b1));

  // R9: full implies almost full
  a_r9_full_in_af: assert property (@(posedge wr_clk) disable iff (rst)
    full |-> almost_full);

  // R8: empty implies almost empty
  a_r8_empty_in_ae: assert property (@(posedge rd_clk) disable iff (rst)
    empty |-> almost_empty);

  // R13: Gray pointers change at most one bit per edge
  a_r13_wr_gray_step: assert property (@(posedge wr_clk) disable iff (rst)
    $onehot0(wr_gray ^ $past(wr_gray)));

  a_r13_rd_gray_step: assert property (@(posedge rd_clk) disable iff (rst)
    $onehot0(rd_gray ^ $past(rd_gray)));

endmodule

bind dcf_fifo9 dcf_fifo9_chk #(.PW(PW)) u_chk (
  .wr_clk       (wr_clk),
  .rd_clk       (rd_clk),
  .rst          (rst),
  .wr_en_n      (wr_en_n),
  .wr_en_ld     (wr_en_ld),
  .rd_en_n      (rd_en_n),
  .rd_en        (rd_en),
  .full         (full),
  .almost_full  (almost_full),
  .empty        (empty),
  .almost_empty (almost_empty),
  .wr_ptr       (wr_ptr_bin),
  .rd_ptr       (rd_ptr_bin),
  .wr_gray      (wr_ptr_gray),
  .rd_gray      (rd_ptr_gray),
  .rd_word      (rd_word)
);

// File: tb/dcf_fifo9_tb_top.sv
`timescale 1ns/1ps
module dcf_fifo9_tb_top;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] wr_data = '0;
  logic       wr_en_n = 1'b1;
  logic       wr_en_ld = 1'b1;
  logic       rd_en_n = 1'b1;
  logic       rd_en = 1'b1;
  logic       out_en = 1'b1;
  wire  [8:0] rd_q;
  logic       empty, almost_empty, full, almost_full;

  always #4 clk = ~clk;

  dcf_fifo9 #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst(rst),
    .wr_data(wr_data), .wr_en_n(wr_en_n), .wr_en_ld(wr_en_ld),
    .rd_en_n(rd_en_n), .rd_en(rd_en), .out_en(out_en),
    .rd_q(rd_q), .empty(empty), .almost_empty(almost_empty),
    .full(full), .almost_full(almost_full)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;
  int seq = 1;

  // reference model state
  logic [8:0] mq[$];
  int  wtot = 0, rtot = 0;
  int  hw[3] = '{0, 0, 0};
  int  hr[3] = '{0, 0, 0};
  int  m_lowoff = 7, m_highoff = 7;
  bit  m_sel = 0;
  bit  m_empty = 1, m_full = 0, m_aef = 1, m_aff = 0;
  logic [8:0] m_q = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    mq.delete();
    wtot = 0; rtot = 0;
    for (int i = 0; i < 3; i++) begin hw[i] = 0; hr[i] = 0; end
    m_empty = 1; m_full = 0; m_aef = 1; m_aff = 0; m_q = '0;
  endtask

  always @(posedge rst) model_clear();

  always @(posedge clk) begin
    bit wa, ra;
    if (rst) begin
      if (wr_en_ld) begin
        m_lowoff = 7; m_highoff = 7; m_sel = 0;
      end else if (!wr_en_n) begin
        if (!m_sel) m_lowoff = int'(wr_data); else m_highoff = int'(wr_data);
        m_sel = ~m_sel;
      end
      model_clear();
    end else begin
      wa = !wr_en_n && wr_en_ld && !m_full;
      ra = !rd_en_n && rd_en && !m_empty;
      if (wa) begin mq.push_back(wr_data); wtot++; end
      if (ra) begin m_q = mq.pop_front(); rtot++; end
      m_empty = ((hw[2] - rtot) == 0);
      m_aef   = ((hw[2] - rtot) <= m_lowoff);
      m_full  = ((wtot - hr[2]) == DEPTH);
      m_aff   = ((wtot - hr[2]) + m_highoff >= DEPTH);
      hw[2] = hw[1]; hw[1] = hw[0]; hw[0] = wtot;
      hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = rtot;
    end
    started = 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk(empty === m_empty, "R6 empty (R13 crossing delay)", int'(empty), int'(m_empty));
      chk(full === m_full, "R7 full (R13 crossing delay)", int'(full), int'(m_full));
      chk(almost_empty === m_aef, "R8 almost_empty", int'(almost_empty), int'(m_aef));
      chk(almost_full === m_aff, "R9 almost_full", int'(almost_full), int'(m_aff));
      if (out_en) chk(rd_q === m_q, "R1 read word", int'(rd_q), int'(m_q));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    wr_en_n = 1; rd_en_n = 1;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en_n = 0; wr_data = 9'(seq); seq++; step();
    end
    wr_en_n = 1;
  endtask

  task automatic pop_words(input int n);
    for (int i = 0; i < n; i++) begin rd_en_n = 0; rd_en = 1; step(); end
    rd_en_n = 1;
  endtask

  task automatic random_run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      int pw;
      pw = (((c / 150) % 2) == 0) ? 70 : 30;
      wr_en_n  = (($urandom % 100) >= pw);
      wr_en_ld = (($urandom % 10) != 0);
      wr_data  = 9'($urandom);
      rd_en_n  = (($urandom % 100) >= (100 - pw));
      rd_en    = (($urandom % 10) != 0);
      out_en   = (($urandom % 8) != 0);
      step();
    end
    wr_en_ld = 1; rd_en = 1; out_en = 1;
    idle(2);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [8:0] last_good, held;
    step(); step(); step();
    // R11 reset state
    @(negedge clk);
    chk(empty === 1'b1, "R11 empty in reset", int'(empty), 1);
    chk(almost_empty === 1'b1, "R11 almost_empty in reset", int'(almost_empty), 1);
    chk(full === 1'b0, "R11 full in reset", int'(full), 0);
    chk(almost_full === 1'b0, "R11 almost_full in reset", int'(almost_full), 0);
    chk(rd_q === 9'd0, "R11 R1 output reset", int'(rd_q), 0);

    // R10 load low mark 3, high mark 5
    step();
    wr_en_ld = 0; step();
    wr_en_n = 0; wr_data = 9'd3; step();
    wr_data = 9'd5; step();
    wr_en_n = 1; step();
    rst = 0; step();
    wr_en_ld = 1;

    push_words(3); idle(5);
    @(negedge clk);
    chk(almost_empty === 1'b1, "R10 low mark 3, count 3", int'(almost_empty), 1);
    push_words(1); idle(5);
    @(negedge clk);
    chk(almost_empty === 1'b0, "R10 low mark 3, count 4", int'(almost_empty), 0);
    push_words(DEPTH - 6 - 4); idle(5);
    @(negedge clk);
    chk(almost_full === 1'b0, "R10 high mark 5, count 58", int'(almost_full), 0);
    push_words(1); idle(5);
    @(negedge clk);
    chk(almost_full === 1'b1, "R10 high mark 5, count 59", int'(almost_full), 1);

    // R2 five back-to-back writes fill it on the last edge (R7)
    last_good = 9'(seq + 4);
    push_words(5);
    @(negedge clk);
    chk(full === 1'b1, "R2 R7 full right after word DEPTH", int'(full), 1);

    // R3 writes while full are dropped
    for (int i = 0; i < 2; i++) begin wr_en_n = 0; wr_data = 9'h1AA; step(); end
    wr_en_n = 1; idle(2);
    @(negedge clk);
    chk(full === 1'b1, "R3 still full after dropped writes", int'(full), 1);

    // R4 back-to-back drain
    pop_words(DEPTH);
    @(negedge clk);
    chk(empty === 1'b1, "R4 empty on the last read edge", int'(empty), 1);
    chk(rd_q === last_good, "R3 last word is the last accepted one", int'(rd_q), int'(last_good));

    // R5 reads while empty
    pop_words(3);
    @(negedge clk);
    chk(rd_q === last_good, "R5 output held on empty reads", int'(rd_q), int'(last_good));

    // R12 output enable
    held = 9'(seq + 1);
    push_words(4); idle(5);
    out_en = 0;
    pop_words(2); idle(2);
    out_en = 1; step();
    @(negedge clk);
    chk(rd_q === held, "R12 reads continue while released", int'(rd_q), int'(held));
    pop_words(2); idle(3);

    random_run(3000);

    // R11 mid-run reset restores defaults
    rst = 1; wr_en_ld = 1; idle(3);
    @(negedge clk);
    chk(empty === 1'b1, "R11 empty after reset", int'(empty), 1);
    chk(full === 1'b0, "R11 full cleared by reset", int'(full), 0);
    rst = 0; step();
    push_words(7); idle(5);
    @(negedge clk);
    chk(almost_empty === 1'b1, "R11 default low mark 7, count 7", int'(almost_empty), 1);
    push_words(1); idle(5);
    @(negedge clk);
    chk(almost_empty === 1'b0, "R11 default low mark 7, count 8", int'(almost_empty), 0);

    random_run(2000);

    done = 1;
    finish_run();
  end

endmodule